// File: doc/BRIEF.md
# Vector Accumulator Cell with Offset Read

This block is one accumulator cell of an array-oriented processor. It holds two registers of `WORD_W` bits. The primary register, A, receives vectors packed right-justified as elements of `ELEM_W` bits. The secondary register, B, collects results and has a direct output of its own.

Register A is read through an offset decoder. A 5-bit offset shifts the value left by that many bit positions. Bits pushed past the top of the word are dropped and zeros enter from the bottom, so a right-justified vector can be realigned for a neighbour without a rotate.

The cell also runs reductions and scans. Each step adds the lowest element of A into the low lane of B, then shifts A right by one element. A start pulse runs a programmed number of these steps back to back. In scan mode every intermediate sum is marked valid. In reduce mode only the final sum is marked valid. Single steps, a direct copy of A into B, and a clear are also available.

Top module: `vacc_cell`

## Requirements
- R1: After reset, A and B are zero, and `rd_o`, `b_o`, `b_vld_o`, `done_o` and `busy_o` are all 0.
- R2: A load writes `load_data_i` into A at the clock edge. With `offs_i` = 0, `rd_o` then equals the loaded word.
- R3: `rd_o` equals A shifted left by `offs_i` bit positions (0 to 31), with bits above bit 31 dropped and zeros in the vacated low bits. It follows `offs_i` in the same cycle, with no clock edge in between.
- R4: When the cell is idle and the transfer request is the only request, B takes the value of A at the next edge. A is unchanged.
- R5: A clear zeroes A and B, aborts any running sequence (`busy_o` falls and no `done_o` follows) and outranks every other request.
- R6: A single step makes B[ELEM_W-1:0] = B[ELEM_W-1:0] + A[ELEM_W-1:0] modulo 2^ELEM_W and leaves the upper bits of B unchanged. It shifts A right by `ELEM_W` bits with zero fill and pulses `b_vld_o` for one cycle with `done_o` low.
- R7: A start with `scan_i` = 0 and count n (1 to WORD_W/ELEM_W) leaves B equal to the zero-extended wrapped sum of the n lowest elements of A. `b_vld_o` and `done_o` are high together for one cycle only, in the cycle after the n-th step edge. The first step happens at the start edge. `busy_o` is high between the first step and the last step.
- R8: A start with `scan_i` = 1 holds `b_vld_o` high in each of the n cycles after the n step edges, and `b_o` shows the running sum each time. `done_o` rises only with the final sum.
- R9: Element addition wraps on overflow and never saturates. With 16-bit elements, 16'hFFFF + 16'h0001 gives 16'h0000.
- R10: A start is ignored while `busy_o` is high, and also when its count is 0 or greater than WORD_W/ELEM_W. An ignored start changes neither A nor B.
- R11: A load outranks accumulation. A start in the same cycle as a load is dropped. A load during a running sequence stalls that cycle's step: no `b_vld_o`, and the step count is kept. The sequence then resumes on the new A.
- R12: When idle, the requests rank clear, load, start, step, transfer. Only the highest-ranked request takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Zero A and B, abort sequence |
| load_i | input | 1 | Load A from `load_data_i` |
| load_data_i | input | WORD_W | Right-justified packed vector |
| xfer_i | input | 1 | Copy A into B |
| step_i | input | 1 | One accumulate step |
| start_i | input | 1 | Begin reduce or scan sequence |
| scan_i | input | 1 | Sequence mode: 1 scan, 0 reduce |
| count_i | input | CNT_W | Element count for the sequence |
| offs_i | input | OFFS_W | Read offset for the A decoder |
| rd_o | output | WORD_W | Offset-shifted view of A |
| b_o | output | WORD_W | Direct output of B |
| b_vld_o | output | 1 | B holds a result worth taking |
| done_o | output | 1 | Final step of a sequence completed |
| busy_o | output | 1 | Sequence steps still pending |

## Verification
The checker watches several rules on every cycle:
- the low bits of `rd_o` below the offset are zero;
- `done_o` always comes with `b_vld_o` and never while `busy_o` is high;
- a clear leaves the cell idle and B zero;
- a load writes A;
- a load during a sequence stalls it;
- a lone idle transfer copies A into B.

The wrapped sums, the exact cycle of each valid strobe in scan and reduce modes, the rejection of bad counts and of starts while busy, and the request ranking can be shown only by the bench's directed scenarios, which compare `b_o` and `rd_o` against sums computed from the loaded words.

// File: rtl/vacc_pkg.sv
package vacc_pkg;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_CLEAR = 3'd1,
      OP_LOAD  = 3'd2,
      OP_SEQ   = 3'd3,
      OP_START = 3'd4,
      OP_STEP  = 3'd5,
      OP_XFER  = 3'd6
   } vacc_op_e;

endpackage

// File: rtl/vacc_offset_dec.sv
module vacc_offset_dec #(
   parameter int WORD_W = 32,
   localparam int OFFS_W = $clog2(WORD_W)
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [OFFS_W-1:0] offs_i,
   output logic [WORD_W-1:0] word_o
);

   logic [WORD_W-1:0] stage [OFFS_W+1];

   assign stage[0] = word_i;

   for (genvar k = 0; k < OFFS_W; k++) begin : g_stage
      assign stage[k+1] = offs_i[k] ? (stage[k] << (1 << k)) : stage[k];
   end

   assign word_o = stage[OFFS_W];

endmodule

// File: rtl/vacc_lane_add.sv
module vacc_lane_add #(
   parameter int ELEM_W = 16
) (
   input  logic [ELEM_W-1:0] x_i,
   input  logic [ELEM_W-1:0] y_i,
   output logic [ELEM_W-1:0] sum_o
);

   if (ELEM_W == 1) begin : g_bit
      assign sum_o = x_i ^ y_i;
   end else begin : g_word
      assign sum_o = x_i + y_i;
   end

endmodule

// File: rtl/vacc_arb.sv
module vacc_arb
   import vacc_pkg::*;
#(
   parameter int NUM_ELEM = 2,
   localparam int CNT_W = $clog2(NUM_ELEM + 1)
) (
   input  logic             clear_i,
   input  logic             load_i,
   input  logic             busy_i,
   input  logic             start_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             step_i,
   input  logic             xfer_i,
   output vacc_op_e         op_o
);

   logic cnt_ok;

   assign cnt_ok = (count_i != '0) && (int'(count_i) <= NUM_ELEM);

   always_comb begin
      if (clear_i)                 op_o = OP_CLEAR;
      else if (load_i)             op_o = OP_LOAD;
      else if (busy_i)             op_o = OP_SEQ;
      else if (start_i && cnt_ok)  op_o = OP_START;
      else if (step_i)             op_o = OP_STEP;
      else if (xfer_i)             op_o = OP_XFER;
      else                         op_o = OP_NONE;
   end

endmodule

// File: rtl/vacc_seq.sv
module vacc_seq
   import vacc_pkg::*;
#(
   parameter int NUM_ELEM = 2,
   localparam int CNT_W = $clog2(NUM_ELEM + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  vacc_op_e         op_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             scan_i,
   output logic             busy_o,
   output logic             vld_o,
   output logic             done_o
);

   logic [CNT_W-1:0] rem_q;
   logic             scan_q;
   logic             last;

   assign last = (rem_q == CNT_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rem_q  <= '0;
         scan_q <= 1'b0;
         busy_o <= 1'b0;
         vld_o  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         unique case (op_i)
            OP_CLEAR: begin
               rem_q  <= '0;
               busy_o <= 1'b0;
               vld_o  <= 1'b0;
               done_o <= 1'b0;
            end
            OP_SEQ: begin
               rem_q  <= rem_q - CNT_W'(1);
               busy_o <= !last;
               vld_o  <= scan_q || last;
               done_o <= last;
            end
            OP_START: begin
               scan_q <= scan_i;
               rem_q  <= count_i - CNT_W'(1);
               busy_o <= (count_i != CNT_W'(1));
               vld_o  <= scan_i || (count_i == CNT_W'(1));
               done_o <= (count_i == CNT_W'(1));
            end
            OP_STEP: begin
               vld_o  <= 1'b1;
               done_o <= 1'b0;
            end
            default: begin
               vld_o  <= 1'b0;
               done_o <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/vacc_cell.sv
module vacc_cell
   import vacc_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int ELEM_W = 16,
   localparam int OFFS_W   = $clog2(WORD_W),
   localparam int NUM_ELEM = WORD_W / ELEM_W,
   localparam int CNT_W    = $clog2(NUM_ELEM + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_data_i,
   input  logic              xfer_i,
   input  logic              step_i,
   input  logic              start_i,
   input  logic              scan_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [OFFS_W-1:0] offs_i,
   output logic [WORD_W-1:0] rd_o,
   output logic [WORD_W-1:0] b_o,
   output logic              b_vld_o,
   output logic              done_o,
   output logic              busy_o
);

   if (WORD_W % ELEM_W != 0) begin : g_bad_elem
      $error("vacc_cell: WORD_W must be a multiple of ELEM_W");
   end
   if ((1 << OFFS_W) != WORD_W) begin : g_bad_word
      $error("vacc_cell: WORD_W must be a power of two");
   end

   vacc_op_e          op;
   logic [WORD_W-1:0] a_q;
   logic [WORD_W-1:0] b_q;
   logic [ELEM_W-1:0] lane_sum;
   logic [ELEM_W-1:0] lane_base;
   logic [WORD_W-1:0] a_shr;

   vacc_arb #(.NUM_ELEM(NUM_ELEM)) u_arb (
      .clear_i (clear_i),
      .load_i  (load_i),
      .busy_i  (busy_o),
      .start_i (start_i),
      .count_i (count_i),
      .step_i  (step_i),
      .xfer_i  (xfer_i),
      .op_o    (op)
   );

   vacc_seq #(.NUM_ELEM(NUM_ELEM)) u_seq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_i    (op),
      .count_i (count_i),
      .scan_i  (scan_i),
      .busy_o  (busy_o),
      .vld_o   (b_vld_o),
      .done_o  (done_o)
   );

   // A fresh sequence starts its sum from zero.
   assign lane_base = (op == OP_START) ? '0 : b_q[ELEM_W-1:0];

   vacc_lane_add #(.ELEM_W(ELEM_W)) u_add (
      .x_i   (lane_base),
      .y_i   (a_q[ELEM_W-1:0]),
      .sum_o (lane_sum)
   );

   assign a_shr = a_q >> ELEM_W;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         a_q <= '0;
         b_q <= '0;
      end else begin
         unique case (op)
            OP_CLEAR: begin
               a_q <= '0;
               b_q <= '0;
            end
            OP_LOAD: a_q <= load_data_i;
            OP_START: begin
               a_q <= a_shr;
               b_q <= {{(WORD_W-ELEM_W){1'b0}}, lane_sum};
            end
            OP_SEQ, OP_STEP: begin
               a_q <= a_shr;
               b_q[ELEM_W-1:0] <= lane_sum;
            end
            OP_XFER: b_q <= a_q;
            default: ;
         endcase
      end
   end

   vacc_offset_dec #(.WORD_W(WORD_W)) u_dec (
      .word_i (a_q),
      .offs_i (offs_i),
      .word_o (rd_o)
   );

   assign b_o = b_q;

endmodule

// File: rtl/vacc_cell_chk.sv
module vacc_cell_chk #(
   parameter int WORD_W = 32,
   localparam int OFFS_W = $clog2(WORD_W)
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              clear_i,
   input logic              load_i,
   input logic [WORD_W-1:0] load_data_i,
   input logic              xfer_i,
   input logic              step_i,
   input logic              start_i,
   input logic [OFFS_W-1:0] offs_i,
   input logic [WORD_W-1:0] rd_o,
   input logic [WORD_W-1:0] b_o,
   input logic              b_vld_o,
   input logic              done_o,
   input logic              busy_o,
   input logic [WORD_W-1:0] a_q
);

   // R3: vacated low bits are zero
   a_r3_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_o & ~({WORD_W{1'b1}} << offs_i)) == '0);

   // R7: completion always carries a valid result and ends busy
   a_r7_done_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (b_vld_o && !busy_o));

   // R5: clear leaves the cell idle with B zero
   a_r5_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (!busy_o && !b_vld_o && !done_o && b_o == '0));

   // R2: load writes A
   a_r2_load_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && !clear_i) |=> (a_q == $past(load_data_i)));

   // R11: load during a sequence stalls it
   a_r11_load_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && load_i && !clear_i) |=> (busy_o && !b_vld_o));

   // R4: a lone idle transfer copies A into B
   a_r4_xfer_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (xfer_i && !busy_o && !clear_i && !load_i && !start_i && !step_i)
      |=> (b_o == $past(a_q) && $stable(a_q)));

endmodule

bind vacc_cell vacc_cell_chk #(.WORD_W(WORD_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .clear_i     (clear_i),
   .load_i      (load_i),
   .load_data_i (load_data_i),
   .xfer_i      (xfer_i),
   .step_i      (step_i),
   .start_i     (start_i),
   .offs_i      (offs_i),
   .rd_o        (rd_o),
   .b_o         (b_o),
   .b_vld_o     (b_vld_o),
   .done_o      (done_o),
   .busy_o      (busy_o),
   .a_q         (a_q)
);

// File: tb/vacc_cell_tb.sv
module vacc_cell_tb;

   localparam int WORD_W = 32;
   localparam int ELEM_W = 16;
   localparam int OFFS_W = 5;
   localparam int CNT_W  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clear_i = 0, load_i = 0, xfer_i = 0, step_i = 0;
   logic              start_i = 0, scan_i = 0;
   logic [CNT_W-1:0]  count_i = '0;
   logic [OFFS_W-1:0] offs_i = '0;
   logic [WORD_W-1:0] load_data_i = '0;
   logic [WORD_W-1:0] rd_o, b_o;
   logic              b_vld_o, done_o, busy_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   vacc_cell #(.WORD_W(WORD_W), .ELEM_W(ELEM_W)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .clear_i(clear_i), .load_i(load_i),
      .load_data_i(load_data_i), .xfer_i(xfer_i), .step_i(step_i),
      .start_i(start_i), .scan_i(scan_i), .count_i(count_i), .offs_i(offs_i),
      .rd_o(rd_o), .b_o(b_o), .b_vld_o(b_vld_o), .done_o(done_o),
      .busy_o(busy_o)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      clear_i = 0; load_i = 0; xfer_i = 0; step_i = 0; start_i = 0;
      scan_i = 0; count_i = '0;
   endtask

   // drive for one edge, then sample at the following falling edge
   task automatic cyc();
      @(negedge clk);
      idle();
   endtask

   task automatic do_load(logic [31:0] d);
      load_i = 1; load_data_i = d; cyc();
   endtask

   task automatic do_clear();
      clear_i = 1; cyc();
   endtask

   task automatic t_reset();
      check("R1 rd", rd_o, 0);
      check("R1 b", b_o, 0);
      check("R1 flags", {29'd0, b_vld_o, done_o, busy_o}, 0);
   endtask

   task automatic t_load_offset();
      do_load(32'h8000_0001);
      offs_i = 0; #1 check("R2 load offs0", rd_o, 32'h8000_0001);
      offs_i = 1; #1 check("R3 offs1", rd_o, 32'h0000_0002);
      offs_i = 31; #1 check("R3 offs31", rd_o, 32'h8000_0000);
      do_load(32'hFFFF_FFFF);
      offs_i = 4; #1 check("R3 offs4", rd_o, 32'hFFFF_FFF0);
      offs_i = 16; #1 check("R3 offs16", rd_o, 32'hFFFF_0000);
      offs_i = 0;
   endtask

   task automatic t_xfer_step();
      do_clear();
      do_load(32'h1234_0005);
      xfer_i = 1; cyc();
      check("R4 xfer b", b_o, 32'h1234_0005);
      check("R4 xfer a", rd_o, 32'h1234_0005);
      do_load(32'h0007_0003);
      step_i = 1; cyc();
      check("R6 step b", b_o, 32'h1234_0008);
      check("R6 step a", rd_o, 32'h0000_0007);
      check("R6 step vld", {b_vld_o, done_o}, 2'b10);
      cyc();
      check("R6 vld pulse", b_vld_o, 0);
   endtask

   task automatic t_reduce();
      do_load(32'h0020_0011);
      start_i = 1; count_i = 2; scan_i = 0; cyc();
      check("R7 mid", {b_vld_o, done_o, busy_o}, 3'b001);
      cyc();
      check("R7 sum", b_o, 32'h0000_0031);
      check("R7 end", {b_vld_o, done_o, busy_o}, 3'b110);
      cyc();
      check("R7 one pulse", {b_vld_o, done_o}, 0);
   endtask

   task automatic t_scan();
      do_load(32'h0100_0002);
      start_i = 1; count_i = 2; scan_i = 1; cyc();
      check("R8 step1 b", b_o, 32'h0000_0002);
      check("R8 step1 flags", {b_vld_o, done_o, busy_o}, 3'b101);
      cyc();
      check("R8 step2 b", b_o, 32'h0000_0102);
      check("R8 step2 flags", {b_vld_o, done_o, busy_o}, 3'b110);
   endtask

   task automatic t_wrap();
      do_load(32'h0001_FFFF);
      start_i = 1; count_i = 2; cyc(); cyc();
      check("R9 wrap", b_o, 32'h0000_0000);
      check("R9 done", done_o, 1);
   endtask

   task automatic t_ignore();
      do_clear();
      do_load(32'h0003_0004);
      xfer_i = 1; cyc();
      start_i = 1; count_i = 0; cyc();
      check("R10 cnt0 a", rd_o, 32'h0003_0004);
      check("R10 cnt0 b", {b_o[31:1], busy_o}, {31'h0001_8002, 1'b0});
      start_i = 1; count_i = 3; cyc();
      check("R10 cnt3", {rd_o[15:0], b_o[15:0]}, 32'h0004_0004);
      start_i = 1; count_i = 2; cyc();
      start_i = 1; count_i = 1; scan_i = 1; cyc();
      check("R10 busy start b", b_o, 32'h0000_0007);
      cyc();
      check("R10 busy start dropped", {b_vld_o, busy_o}, 0);
   endtask

   task automatic t_load_prio();
      do_load(32'h0000_0009);
      load_i = 1; load_data_i = 32'h0002_0001; start_i = 1; count_i = 1; cyc();
      check("R11 start dropped", {b_vld_o, busy_o}, 0);
      check("R11 load wins", rd_o, 32'h0002_0001);
      start_i = 1; count_i = 2; cyc();
      load_i = 1; load_data_i = 32'h0000_0040; cyc();
      check("R11 stall", {b_vld_o, busy_o, b_o[15:0]}, {2'b01, 16'h0001});
      cyc();
      check("R11 resume", b_o, 32'h0000_0041);
      check("R11 done", done_o, 1);
   endtask

   task automatic t_clear_abort();
      do_load(32'h0005_0006);
      start_i = 1; count_i = 2; cyc();
      clear_i = 1; step_i = 1; cyc();
      check("R5 cleared", {b_o, rd_o}, 0);
      check("R5 abort", {b_vld_o, done_o, busy_o}, 0);
      cyc();
      check("R5 no done", done_o, 0);
   endtask

   task automatic t_rank();
      do_load(32'h0000_0010);
      start_i = 1; count_i = 1; step_i = 1; xfer_i = 1; cyc();
      check("R12 start wins", {b_vld_o, done_o}, 2'b11);
      do_load(32'h0000_0002);
      step_i = 1; xfer_i = 1; cyc();
      check("R12 step over xfer", b_o, 32'h0000_0012);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1;
            @(negedge clk);
            t_reset();
            t_load_offset();
            t_xfer_step();
            t_reduce();
            t_scan();
            t_wrap();
            t_ignore();
            t_load_prio();
            t_clear_abort();
            t_rank();
         end
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule